// File: doc/BRIEF.md
# Control Block CRC Engine

This block computes and checks the two 16-bit checksums that guard a fixed-format command block. The block is stored as a big-endian byte buffer. The caller streams one coverage region at a time into the engine, one byte per accepted transfer. A first marker opens the region and a last marker closes it. With the first byte the caller also gives a region select, a layout select and the used length of the parameter area.

The invariant region is made of a 24-byte header span followed by the used part of the input-parameter area. That area holds 96 bytes in the newer layout and 104 bytes in the older one. The variant region is only the used part of the output-parameter area, which holds at most 64 bytes. Any bytes that arrive after the covered length are accepted but do not change the checksum. This lets the caller stream a whole fixed-size area without trimming it.

In generate mode the engine reports the checksum so it can be written into the block. In check mode it also compares the result with an expected value supplied on a side input and flags any difference.

Top module: `crcb_engine`

## Requirements
- R1: The checksum uses generator 0x1021. The register is preset to 0xFFFF when a region opens. Each covered byte is shifted in most significant bit first, and no final XOR is applied. For the ASCII bytes "123456789" the result is 0x29B1.
- R2: With `region_sel`=0 (invariant), the covered span is the first 24 + n bytes of the region, where n is `used_len` clamped to the input area size.
- R3: The input area size is 96 bytes when `layout_new`=1 and 104 bytes when `layout_new`=0.
- R4: With `region_sel`=1 (variant), the covered span is the first n bytes, where n is `used_len` clamped to 64. When n=0, the result is 0xFFFF.
- R5: Bytes beyond the covered span are accepted and have no effect on the result.
- R6: `done` is high for one cycle, in the cycle after the byte carrying `in_last` is accepted. `crc_out` changes only in that cycle and then holds until the next `done`.
- R7: If `mode_chk`=1 was given with the first byte, `mismatch` is high with `done` exactly when the result differs from `exp_crc` as sampled with the last byte. If `mode_chk`=0, `mismatch` stays low.
- R8: `len_err` is updated with `done`. It is set when `used_len` exceeded the area size of the selected region, and cleared otherwise.
- R9: While reset is held, `done`, `mismatch`, `len_err` and `in_ready` are 0 and `crc_out` is 0xFFFF. `in_ready` rises on the first clock after reset is released.
- R10: A byte carrying `in_first` always opens a fresh region, even if the previous region was never closed. The new region's length rules come from the inputs present with that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| in_data | input | 8 | Stream byte, buffer order |
| in_first | input | 1 | Byte opens a region |
| in_last | input | 1 | Byte closes a region |
| region_sel | input | 1 | 0 invariant, 1 variant; sampled with the first byte |
| layout_new | input | 1 | 1 selects the 96-byte input area; sampled with the first byte |
| mode_chk | input | 1 | 1 check, 0 generate; sampled with the first byte |
| used_len | input | LEN_W | Used length of the parameter area; sampled with the first byte |
| exp_crc | input | 16 | Expected checksum; sampled with the last byte |
| crc_out | output | 16 | Result of the last closed region |
| done | output | 1 | One-cycle result strobe |
| mismatch | output | 1 | Check-mode difference, valid with `done` |
| len_err | output | 1 | Used length exceeded the area, valid with `done` |

## Verification
Some properties are checked on every cycle by assertions:
- the checksum register holds through idle cycles and through bytes outside the covered span;
- a region with no covered bytes leaves the preset value;
- the first invariant byte is always covered;
- the clamp raises the length error;
- `done` follows each closing byte and nothing else, and `crc_out` moves only with `done`.

The numeric result itself is covered by the bench scenarios. These compare against an independent model over the known check string, over both layouts at and past the area bounds, over an empty variant span, over single-byte regions, over an abandoned region restarted by a new first marker, and over check mode with right and wrong expected values.

// File: rtl/crcb_pkg.sv
package crcb_pkg;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  // one byte into the register, most significant data bit first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  function automatic logic [31:0] clamp_len(input logic [31:0] n, input logic [31:0] cap);
    return (n > cap) ? cap : n;
  endfunction

endpackage

// File: rtl/crcb_len_ctl.sv
module crcb_len_ctl
  import crcb_pkg::*;
#(
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned HDR_BYTES = 24,
  parameter int unsigned AREA_NEW  = 96,
  parameter int unsigned AREA_OLD  = 104,
  parameter int unsigned AREA_OUT  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             first,
  input  logic             region_var,
  input  logic             layout_new,
  input  logic [LEN_W-1:0] used_len,
  output logic             incl,
  output logic             err_now
);

  localparam int unsigned AREA_MAX = (AREA_OLD > AREA_NEW) ? AREA_OLD : AREA_NEW;
  localparam int unsigned LIM_INV  = HDR_BYTES + AREA_MAX;
  localparam int unsigned LIM_MAX  = (LIM_INV > AREA_OUT) ? LIM_INV : AREA_OUT;
  localparam int unsigned CNT_W    = $clog2(LIM_MAX + 1);

  logic [31:0]      len32, area_sel, lim_calc;
  logic             err_calc, err_q;
  logic [CNT_W-1:0] lim_q, cnt_q, lim_now, idx_now;

  always_comb begin
    len32    = 32'(used_len);
    area_sel = region_var ? AREA_OUT : (layout_new ? AREA_NEW : AREA_OLD);
    err_calc = len32 > area_sel;
    lim_calc = (region_var ? 32'd0 : HDR_BYTES) + clamp_len(len32, area_sel);
    lim_now  = first ? CNT_W'(lim_calc) : lim_q;
    idx_now  = first ? '0 : cnt_q;
    incl     = idx_now < lim_now;
    err_now  = first ? err_calc : err_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (acc) begin
      lim_q <= lim_now;
      err_q <= err_now;
      cnt_q <= (idx_now == CNT_W'(LIM_MAX)) ? idx_now : idx_now + 1'b1;
    end
  end

  AST_VAR_CLAMP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && first && region_var && (len32 > AREA_OUT)) |=> err_q); // R8
  AST_NEW_AREA_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && first && !region_var && layout_new && (len32 <= AREA_NEW)) |=> !err_q); // R3
  AST_HDR_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && first && !region_var) |-> incl); // R2

endmodule

// File: rtl/crcb_crc_core.sv
module crcb_crc_core
  import crcb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc,
  input  logic        first,
  input  logic        incl,
  input  logic [7:0]  data,
  output logic [15:0] crc_now
);

  logic [15:0] crc_q, crc_base;

  always_comb begin
    crc_base = first ? CRC_SEED : crc_q;
    crc_now  = incl ? crc16_step(crc_base, data) : crc_base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else if (acc) crc_q <= crc_now;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(crc_q)); // R5
  AST_TAIL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !first && !incl) |=> $stable(crc_q)); // R5
  AST_EMPTY_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && first && !incl) |=> (crc_q == 16'hFFFF)); // R4

endmodule

// File: rtl/crcb_engine.sv
module crcb_engine
  import crcb_pkg::*;
#(
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned HDR_BYTES = 24,
  parameter int unsigned AREA_NEW  = 96,
  parameter int unsigned AREA_OLD  = 104,
  parameter int unsigned AREA_OUT  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_first,
  input  logic             in_last,
  input  logic             region_sel,
  input  logic             layout_new,
  input  logic             mode_chk,
  input  logic [LEN_W-1:0] used_len,
  input  logic [15:0]      exp_crc,
  output logic [15:0]      crc_out,
  output logic             done,
  output logic             mismatch,
  output logic             len_err
);

  logic        ready_q, acc, incl, err_now, mode_q, mode_now;
  logic [15:0] crc_now;

  assign acc      = in_valid & ready_q;
  assign in_ready = ready_q;
  assign mode_now = in_first ? mode_chk : mode_q;

  crcb_len_ctl #(
    .LEN_W(LEN_W), .HDR_BYTES(HDR_BYTES), .AREA_NEW(AREA_NEW),
    .AREA_OLD(AREA_OLD), .AREA_OUT(AREA_OUT)
  ) u_len (
    .clk(clk), .rst_n(rst_n), .acc(acc), .first(in_first),
    .region_var(region_sel), .layout_new(layout_new), .used_len(used_len),
    .incl(incl), .err_now(err_now)
  );

  crcb_crc_core u_crc (
    .clk(clk), .rst_n(rst_n), .acc(acc), .first(in_first),
    .incl(incl), .data(in_data), .crc_now(crc_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      mode_q   <= 1'b0;
      done     <= 1'b0;
      crc_out  <= CRC_SEED;
      mismatch <= 1'b0;
      len_err  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      done    <= 1'b0;
      if (acc) mode_q <= mode_now;
      if (acc && in_last) begin
        done     <= 1'b1;
        crc_out  <= crc_now;
        mismatch <= mode_now && (crc_now != exp_crc);
        len_err  <= err_now;
      end
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_last) |=> done); // R6
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(acc && in_last)); // R6
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(crc_out)); // R6
  AST_GEN_NO_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_last && !mode_now) |=> !mismatch); // R7

endmodule

// File: tb/crcb_engine_test.sv
module crcb_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic        region_sel = 1'b0, layout_new = 1'b0, mode_chk = 1'b0;
  logic [7:0]  in_data = 8'h00, used_len = 8'h00;
  logic [15:0] exp_crc = 16'h0000;
  logic        in_ready, done, mismatch, len_err;
  logic [15:0] crc_out;

  int n_chk = 0, n_fail = 0, wd = 0;

  always #4 clk = ~clk;

  crcb_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .region_sel(region_sel), .layout_new(layout_new), .mode_chk(mode_chk),
    .used_len(used_len), .exp_crc(exp_crc), .crc_out(crc_out), .done(done),
    .mismatch(mismatch), .len_err(len_err)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_lim(input logic rv, input logic ln, input int ulen);
    int area;
    area = rv ? 64 : (ln ? 96 : 104);
    return (rv ? 0 : 24) + ((ulen < area) ? ulen : area);
  endfunction

  function automatic logic ref_err(input logic rv, input logic ln, input int ulen);
    return ulen > (rv ? 64 : (ln ? 96 : 104));
  endfunction

  function automatic logic [15:0] ref_crc(input logic [7:0] b[$], input int lim);
    int r;
    r = 'hFFFF;
    for (int i = 0; i < b.size() && i < lim; i++) begin
      r = r ^ (int'(b[i]) << 8);
      for (int k = 0; k < 8; k++) begin
        r = r << 1;
        if (r & 'h10000) r = r ^ 'h11021;
      end
    end
    return r[15:0];
  endfunction

  function automatic logic [7:0] byte_at(input int seed, input int i);
    int v;
    v = (seed < 0) ? ('h31 + i) : (seed * 37 + i * 11 + 5);
    return v[7:0];
  endfunction

  // cycle-by-cycle reference model
  logic [7:0]  mq[$];
  int          m_lim;
  logic        m_eg, m_chk, m_done, m_mis, m_err;
  logic [15:0] m_out;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_done = 1'b0; m_mis = 1'b0; m_err = 1'b0; m_out = 16'hFFFF;
    end else begin
      m_done = 1'b0;
      if (in_valid) begin
        if (in_first) begin
          mq.delete();
          m_lim = ref_lim(region_sel, layout_new, int'(used_len));
          m_eg  = ref_err(region_sel, layout_new, int'(used_len));
          m_chk = mode_chk;
        end
        mq.push_back(in_data);
        if (in_last) begin
          m_out  = ref_crc(mq, m_lim);
          m_done = 1'b1;
          m_mis  = m_chk && (m_out != exp_crc);
          m_err  = m_eg;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(done == m_done, "R6 model done", int'(done), int'(m_done));
      chk(crc_out == m_out, "R1 model crc", int'(crc_out), int'(m_out));
      if (m_done) begin
        chk(mismatch == m_mis, "R7 model mismatch", int'(mismatch), int'(m_mis));
        chk(len_err == m_err, "R8 model len_err", int'(len_err), int'(m_err));
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic send_frame(input logic rv, input logic ln, input logic ck, input int ulen,
                            input int nb, input int seed, input logic wrong, input logic close,
                            input string tag);
    logic [7:0]  bq[$];
    logic [15:0] e;
    logic        er;
    for (int i = 0; i < nb; i++) bq.push_back(byte_at(seed, i));
    e  = ref_crc(bq, ref_lim(rv, ln, ulen));
    er = ref_err(rv, ln, ulen);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = bq[i];
      in_first = (i == 0); in_last = close && (i == nb - 1);
      region_sel = rv; layout_new = ln; mode_chk = ck; used_len = ulen[7:0];
      exp_crc = wrong ? (e ^ 16'h0001) : e;
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    if (close) begin
      chk(done == 1'b1, {tag, " R6 done"}, int'(done), 1);
      chk(crc_out == e, {tag, " crc"}, int'(crc_out), int'(e));
      chk(mismatch == (ck && wrong), {tag, " R7 mismatch"}, int'(mismatch), int'(ck && wrong));
      chk(len_err == er, {tag, " R8 len_err"}, int'(len_err), int'(er));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && mismatch == 1'b0 && len_err == 1'b0, "R9 reset flags",
        int'({done, mismatch, len_err}), 0);
    chk(crc_out == 16'hFFFF, "R9 reset crc", int'(crc_out), 'hFFFF);
    chk(in_ready == 1'b0, "R9 ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready after reset", int'(in_ready), 1);

    send_frame(1'b1, 1'b0, 1'b0, 9, 9, -1, 1'b0, 1'b1, "R1 R4 check string");
    chk(crc_out == 16'h29B1, "R1 known value", int'(crc_out), 'h29B1);
    @(negedge clk);
    chk(crc_out == 16'h29B1 && done == 1'b0, "R6 hold", int'(crc_out), 'h29B1);

    send_frame(1'b1, 1'b0, 1'b0, 0, 3, 4, 1'b0, 1'b1, "R4 R5 empty variant");
    chk(crc_out == 16'hFFFF, "R4 empty gives preset", int'(crc_out), 'hFFFF);
    send_frame(1'b1, 1'b1, 1'b0, 70, 70, 7, 1'b0, 1'b1, "R4 R8 variant clamp");
    send_frame(1'b1, 1'b0, 1'b0, 64, 64, 8, 1'b0, 1'b1, "R4 R8 variant full");
    send_frame(1'b0, 1'b1, 1'b0, 10, 39, 2, 1'b0, 1'b1, "R2 R5 invariant tail");
    send_frame(1'b0, 1'b1, 1'b0, 104, 128, 3, 1'b0, 1'b1, "R3 R8 new layout over");
    send_frame(1'b0, 1'b0, 1'b0, 104, 130, 3, 1'b0, 1'b1, "R3 R8 old layout exact");
    send_frame(1'b0, 1'b0, 1'b0, 200, 130, 5, 1'b0, 1'b1, "R2 R8 old layout over");
    send_frame(1'b0, 1'b1, 1'b0, 0, 24, 6, 1'b0, 1'b1, "R2 header only");
    send_frame(1'b1, 1'b1, 1'b1, 20, 20, 9, 1'b0, 1'b1, "R7 check match");
    send_frame(1'b0, 1'b1, 1'b1, 40, 70, 10, 1'b1, 1'b1, "R7 check differ");
    send_frame(1'b1, 1'b0, 1'b0, 12, 12, 11, 1'b1, 1'b1, "R7 generate ignores exp");
    send_frame(1'b1, 1'b0, 1'b1, 1, 1, 12, 1'b1, 1'b1, "R6 R7 single byte");
    send_frame(1'b1, 1'b1, 1'b1, 30, 30, 13, 1'b0, 1'b0, "R10 abandoned");
    chk(done == 1'b0, "R10 no done for open region", int'(done), 0);
    send_frame(1'b0, 1'b0, 1'b0, 5, 29, 14, 1'b0, 1'b1, "R10 restart");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule